// File: doc/BRIEF.md
# Interlaced Video Sync Generator

This block is the master timing source for an interlaced video path. It runs from a single double-rate sample clock, nominally 27 MHz. A horizontal sample counter and a vertical half-line counter drive three registered outputs: an active-low line sync, an active-low frame sync and a field flag. Two mode inputs select the timing. One picks the 525-line raster (59.94 fields per second) or the 625-line raster (50 fields per second). The other picks a frame-sync pulse three lines long or two and a half lines long.

Each frame holds an odd number of lines. The odd field therefore begins on a line boundary and the even field begins halfway through a line. The frame sync starts on the same clock as the line sync at the start of the odd field, and at mid-line at the start of the even field. The field flag settles a fixed number of clocks before each frame-sync leading edge, so downstream logic can latch it ahead of the sync. The mode inputs are sampled while reset is held and at every frame boundary. A change in the middle of a frame therefore never produces a malformed frame.

Top module: `isync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hsync_n` and `vsync_n` are high and `field` is low. On the first edge with `rst_n` high, `hsync_n` and `vsync_n` both fall.
- R2: `hsync_n` falls once per line: every LINE_525 clocks (default 1716) when `std_625` is 0, and every LINE_625 clocks (default 1728) when it is 1.
- R3: Each `hsync_n` low pulse lasts HS_WIDTH clocks (default 127, about 4.7 µs at 27 MHz).
- R4: A frame holds LINES_525 or LINES_625 lines (both odd). Consecutive `vsync_n` leading edges are half a frame apart, which is LINES × L / 2 clocks for line length L.
- R5: At the start of the odd field, `vsync_n` falls on the same clock as `hsync_n`.
- R6: At the start of the even field, `vsync_n` falls L/2 clocks after the latest `hsync_n` fall, while `hsync_n` is high.
- R7: `vsync_n` stays low for 6 half-lines (3L clocks) when `vs_short` is 0, and for 5 half-lines (2.5L clocks) when it is 1.
- R8: `field` changes FIELD_LEAD clocks (default 32) before each `vsync_n` leading edge. It is 0 for the odd field and 1 for the even field, and it is held constant while `vsync_n` is low.
- R9: A change on `std_625` or `vs_short` in the middle of a frame has no effect until the next odd-field start. The first line of that frame then uses the new timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate sample clock |
| rst_n | input | 1 | Synchronous reset, active low; mode inputs sampled while low |
| std_625 | input | 1 | 1 selects the 625-line / 50 Hz raster, 0 selects 525-line / 59.94 Hz |
| vs_short | input | 1 | 1 selects a 2.5-line frame sync, 0 selects 3 lines |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| field | output | 1 | Field flag: 0 odd field, 1 even field |

## Verification
The horizontal and vertical counters are visible only through edge spacing, so each fault shows up as a wrong interval between edges. A horizontal count that wraps at the wrong value changes the line-sync period on the very next line. A half-line counter that slips moves the even-field frame sync off mid-line, or stretches a field, and this appears within one field. A mode latched at the wrong moment shows as a wrong line period before the frame boundary or after it. A misplaced field decode appears as a lead other than FIELD_LEAD at the next frame-sync edge.

// File: rtl/isg_pkg.sv
package isg_pkg;

   typedef struct packed {
      logic raster625;
      logic vs_short;
   } isg_mode_t;

   function automatic int unsigned isg_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned isg_min(int unsigned a, int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/isg_hcount.sv
module isg_hcount #(
   parameter int unsigned LINE_A = 1716,
   parameter int unsigned LINE_B = 1728,
   parameter int unsigned HW     = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_b,
   output logic [HW-1:0] h,
   output logic          half_step,
   output logic          line_wrap
);
   localparam logic [HW-1:0] LAST_A = HW'(LINE_A - 1);
   localparam logic [HW-1:0] LAST_B = HW'(LINE_B - 1);
   localparam logic [HW-1:0] MID_A  = HW'(LINE_A / 2 - 1);
   localparam logic [HW-1:0] MID_B  = HW'(LINE_B / 2 - 1);

   logic [HW-1:0] last_idx;
   logic [HW-1:0] mid_idx;

   assign last_idx  = sel_b ? LAST_B : LAST_A;
   assign mid_idx   = sel_b ? MID_B : MID_A;
   assign line_wrap = (h == last_idx);
   assign half_step = line_wrap || (h == mid_idx);

   always_ff @(posedge clk) begin
      if (!rst_n)         h <= '0;
      else if (line_wrap) h <= '0;
      else                h <= h + 1'b1;
   end

   // Sample index never passes the end of the line for the latched raster
   assert_h_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      h <= last_idx);

endmodule

// File: rtl/isg_vcount.sv
module isg_vcount #(
   parameter int unsigned HALVES_A = 1050,
   parameter int unsigned HALVES_B = 1250,
   parameter int unsigned VW       = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_b,
   input  logic          step,
   output logic [VW-1:0] v,
   output logic          frame_wrap
);
   localparam logic [VW-1:0] LAST_A = VW'(HALVES_A - 1);
   localparam logic [VW-1:0] LAST_B = VW'(HALVES_B - 1);

   logic [VW-1:0] last_idx;

   assign last_idx   = sel_b ? LAST_B : LAST_A;
   assign frame_wrap = step && (v == last_idx);

   always_ff @(posedge clk) begin
      if (!rst_n)          v <= '0;
      else if (frame_wrap) v <= '0;
      else if (step)       v <= v + 1'b1;
   end

   // Half-line index stays inside the frame
   assert_v_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      v <= last_idx);

endmodule

// File: rtl/isg_sync_out.sv
module isg_sync_out
   import isg_pkg::*;
#(
   parameter int unsigned LINE_A  = 1716,
   parameter int unsigned LINE_B  = 1728,
   parameter int unsigned LINES_A = 525,
   parameter int unsigned LINES_B = 625,
   parameter int unsigned HS_W    = 127,
   parameter int unsigned LEAD    = 32,
   parameter int unsigned HW      = 11,
   parameter int unsigned VW      = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  isg_mode_t     mode,
   input  logic [HW-1:0] h,
   input  logic [VW-1:0] v,
   output logic          hs_n,
   output logic          vs_n,
   output logic          field
);
   localparam logic [HW-1:0] HSW_C    = HW'(HS_W);
   localparam logic [HW-1:0] CLR_H_A  = HW'(LINE_A - LEAD);
   localparam logic [HW-1:0] CLR_H_B  = HW'(LINE_B - LEAD);
   localparam logic [HW-1:0] SET_H_A  = HW'(LINE_A / 2 - LEAD);
   localparam logic [HW-1:0] SET_H_B  = HW'(LINE_B / 2 - LEAD);
   localparam logic [VW-1:0] LNS_A    = VW'(LINES_A);
   localparam logic [VW-1:0] LNS_B    = VW'(LINES_B);
   localparam logic [VW-1:0] VH_LONG  = VW'(6);
   localparam logic [VW-1:0] VH_SHORT = VW'(5);

   logic [VW-1:0] lines;
   logic [VW-1:0] vs_len;
   logic [HW-1:0] clr_h;
   logic [HW-1:0] set_h;
   logic          in_odd_vs;
   logic          in_even_vs;
   logic          fld_clr;
   logic          fld_set;

   assign lines  = mode.raster625 ? LNS_B : LNS_A;
   assign vs_len = mode.vs_short ? VH_SHORT : VH_LONG;
   assign clr_h  = mode.raster625 ? CLR_H_B : CLR_H_A;
   assign set_h  = mode.raster625 ? SET_H_B : SET_H_A;

   // Odd field opens at half-line 0, even field at half-line LINES (mid-line)
   assign in_odd_vs  = (v < vs_len);
   assign in_even_vs = (v >= lines) && (v < lines + vs_len);

   // Field flag decoded LEAD samples ahead of each field's first half-line
   assign fld_clr = (v == (lines + lines - 1'b1)) && (h == clr_h);
   assign fld_set = (v == (lines - 1'b1)) && (h == set_h);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_n  <= 1'b1;
         vs_n  <= 1'b1;
         field <= 1'b0;
      end else begin
         hs_n <= !(h < HSW_C);
         vs_n <= !(in_odd_vs || in_even_vs);
         if (fld_clr)      field <= 1'b0;
         else if (fld_set) field <= 1'b1;
      end
   end

   assert_odd_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vs_n) && !field) |-> $fell(hs_n));

   assert_even_midline_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vs_n) && field) |-> hs_n);

   assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_n |-> $stable(field));

   assert_hs_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_n) |=> !hs_n);

endmodule

// File: rtl/isync_gen.sv
module isync_gen
   import isg_pkg::*;
#(
   parameter int unsigned LINE_525   = 1716,
   parameter int unsigned LINE_625   = 1728,
   parameter int unsigned LINES_525  = 525,
   parameter int unsigned LINES_625  = 625,
   parameter int unsigned HS_WIDTH   = 127,
   parameter int unsigned FIELD_LEAD = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic std_625,
   input  logic vs_short,
   output logic hsync_n,
   output logic vsync_n,
   output logic field
);
   localparam int unsigned LINE_MAX  = isg_max(LINE_525, LINE_625);
   localparam int unsigned LINE_MIN  = isg_min(LINE_525, LINE_625);
   localparam int unsigned LINES_MAX = isg_max(LINES_525, LINES_625);
   localparam int unsigned LINES_MIN = isg_min(LINES_525, LINES_625);
   localparam int unsigned HW        = $clog2(LINE_MAX);
   localparam int unsigned VW        = $clog2(2 * LINES_MAX);

   generate
      if ((LINE_525 % 2) != 0 || (LINE_625 % 2) != 0) begin : g_bad_line
         $error("line lengths must be even");
      end
      if ((LINES_525 % 2) == 0 || (LINES_625 % 2) == 0) begin : g_bad_lines
         $error("line counts must be odd for interlace");
      end
      if (LINES_MIN < 7) begin : g_bad_short
         $error("frame too short for the frame-sync window");
      end
      if (HS_WIDTH < 2 || HS_WIDTH >= LINE_MIN / 2) begin : g_bad_hsw
         $error("line sync width out of range");
      end
      if (FIELD_LEAD < 1 || FIELD_LEAD > LINE_MIN / 2) begin : g_bad_lead
         $error("field lead out of range");
      end
   endgenerate

   isg_mode_t     mode_q;
   logic [HW-1:0] h;
   logic [VW-1:0] v;
   logic          half_step;
   logic          line_wrap;
   logic          frame_wrap;

   // Mode is taken during reset and at each frame boundary only
   always_ff @(posedge clk) begin
      if (!rst_n || frame_wrap) begin
         mode_q.raster625 <= std_625;
         mode_q.vs_short  <= vs_short;
      end
   end

   isg_hcount #(
      .LINE_A (LINE_525),
      .LINE_B (LINE_625),
      .HW     (HW)
   ) u_hcount (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_b     (mode_q.raster625),
      .h         (h),
      .half_step (half_step),
      .line_wrap (line_wrap)
   );

   isg_vcount #(
      .HALVES_A (2 * LINES_525),
      .HALVES_B (2 * LINES_625),
      .VW       (VW)
   ) u_vcount (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_b      (mode_q.raster625),
      .step       (half_step),
      .v          (v),
      .frame_wrap (frame_wrap)
   );

   isg_sync_out #(
      .LINE_A  (LINE_525),
      .LINE_B  (LINE_625),
      .LINES_A (LINES_525),
      .LINES_B (LINES_625),
      .HS_W    (HS_WIDTH),
      .LEAD    (FIELD_LEAD),
      .HW      (HW),
      .VW      (VW)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q),
      .h     (h),
      .v     (v),
      .hs_n  (hsync_n),
      .vs_n  (vsync_n),
      .field (field)
   );

   // Frame boundary from the vertical count lands only on a line boundary
   assert_frame_on_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_wrap |-> line_wrap);

   // Latched mode only moves at a frame boundary
   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_wrap) |-> $stable(mode_q));

endmodule

// File: tb/tb_isync_gen.sv
module tb_isync_gen;
   localparam int LA   = 64;
   localparam int LB   = 72;
   localparam int NA   = 11;
   localparam int NB   = 13;
   localparam int HSW  = 5;
   localparam int LEAD = 3;

   // {start 625, start short, later 625, later short, switch mid-frame}
   localparam logic [4:0] VEC [5] = '{5'b00_00_0, 5'b10_00_0, 5'b11_00_0,
                                      5'b01_00_0, 5'b00_11_1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic s625 = 1'b0;
   logic vsh = 1'b0;
   logic hs, vs, fld;
   int   n_chk = 0;
   int   n_bad = 0;

   always #2 clk = ~clk;

   isync_gen #(
      .LINE_525(LA), .LINE_625(LB), .LINES_525(NA), .LINES_625(NB),
      .HS_WIDTH(HSW), .FIELD_LEAD(LEAD)
   ) dut (
      .clk(clk), .rst_n(rst_n), .std_625(s625), .vs_short(vsh),
      .hsync_n(hs), .vsync_n(vs), .field(fld)
   );

   function automatic int llen(bit m);
      return m ? LB : LA;
   endfunction

   function automatic int nlin(bit m);
      return m ? NB : NA;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(bit a6, bit ash, bit b6, bit bsh, bit sw);
      int  cyc, last_hf, last_vf, last_fc, total, sw_at;
      bit  cur6, curs, pend, r9_next, exp_odd, phs, pvs, pfld;
      s625 = a6;
      vsh  = ash;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hs === 1'b1 && vs === 1'b1 && fld === 1'b0, "R1 reset state",
          int'({hs, vs, fld}), 6);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hs === 1'b0 && vs === 1'b0, "R1 first edge after release",
          int'({hs, vs}), 0);
      cur6 = a6; curs = ash; pend = 1'b0; r9_next = 1'b0;
      cyc = 0; last_hf = 0; last_vf = 0; last_fc = -1;
      exp_odd = 1'b1;
      phs = 1'b0; pvs = 1'b0; pfld = fld;
      sw_at = LA * NA / 2 + 10;
      total = sw ? (nlin(a6) * llen(a6) + 2 * nlin(b6) * llen(b6) + 20)
                 : (2 * nlin(a6) * llen(a6) + 20);
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         cyc++;
         if (!hs && phs) begin
            if (r9_next) begin
               chk(cyc - last_hf == llen(cur6), "R9 first line of new mode",
                   cyc - last_hf, llen(cur6));
               r9_next = 1'b0;
            end else begin
               chk(cyc - last_hf == llen(cur6), "R2 line period",
                   cyc - last_hf, llen(cur6));
            end
            last_hf = cyc;
         end
         if (hs && !phs)
            chk(cyc - last_hf == HSW, "R3 line sync width", cyc - last_hf, HSW);
         if (fld !== pfld) last_fc = cyc;
         if (!vs && pvs) begin
            exp_odd = !exp_odd;
            chk(cyc - last_vf == nlin(cur6) * llen(cur6) / 2, "R4 field spacing",
                cyc - last_vf, nlin(cur6) * llen(cur6) / 2);
            if (exp_odd)
               chk(last_hf == cyc, "R5 odd-field sync alignment", last_hf, cyc);
            else
               chk(cyc - last_hf == llen(cur6) / 2, "R6 even-field mid-line",
                   cyc - last_hf, llen(cur6) / 2);
            chk(fld === !exp_odd, "R8 field level", int'(fld), int'(!exp_odd));
            if (last_fc >= 0)
               chk(cyc - last_fc == LEAD, "R8 field lead", cyc - last_fc, LEAD);
            if (exp_odd && pend) begin
               chk(cyc == nlin(a6) * llen(a6), "R9 switch at frame boundary",
                   cyc, nlin(a6) * llen(a6));
               cur6 = b6; curs = bsh; pend = 1'b0; r9_next = 1'b1;
            end
            last_vf = cyc;
         end
         if (vs && !pvs)
            chk(cyc - last_vf == (curs ? 5 : 6) * llen(cur6) / 2,
                "R7 frame sync width", cyc - last_vf,
                (curs ? 5 : 6) * llen(cur6) / 2);
         phs = hs; pvs = vs; pfld = fld;
         if (sw && cyc == sw_at) begin
            s625 = b6;
            vsh  = bsh;
            pend = 1'b1;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 5; i++)
         run(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      // Directed: reset asserted mid-field while frame sync is active
      rst_n = 1'b0;
      @(negedge clk);
      chk(hs === 1'b1 && vs === 1'b1 && fld === 1'b0, "R1 reset mid-run",
          int'({hs, vs, fld}), 6);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule